// File: doc/BRIEF.md
# Wait-State SRAM Strobe Sequencer

This block runs one access at a time to an external asynchronous static RAM, either a read or a write, and produces the control waveforms for it. The outputs are the address, an address-attribute strobe, a read strobe, a write strobe and an enable for the write-data driver. The block is clocked by a fast clock that runs at four times the core rate. A free-running 2-bit phase counter divides each core cycle into four quarter ticks, and every strobe edge falls on one of those quarter ticks. All strobes are active high at the ports. Any pad-level inversion belongs outside the block.

A programmed wait-state count sets how long the access lasts and where each strobe edge falls inside it. The setup, pulse and hold intervals do not simply grow with the count. They change in steps when the count reaches 4 and again when it reaches 8. The core side raises `req` together with the direction, the wait-state count, the address and the write data. `busy` then covers the whole access, and `done` is high during its final core cycle. Data captured by a read is presented on `rdata`.

Inside an access, the position is a quarter-tick index. It is formed by placing a core-cycle counter above the phase counter. Every strobe edge is decoded by comparing this index against limits that are worked out from the wait-state count when the access is accepted.

Top module: `sram_strobe_seq`

## Requirements
- R1: A programmed wait-state count of 0 or 1 behaves exactly like a count of 2. The effective count W is max(ws_cfg, 2).
- R2: An access lasts 4·(W+2) quarter ticks when W is 2..7, and 4·(W+3) quarter ticks when W is 8 or more. `busy` is high for every tick of the access. `done` is high for exactly its last four ticks.
- R3: `mem_aa` is high and `mem_addr` holds the accepted address from tick 0 to the last tick of every access. On writes, `mem_we` rises at tick 3 when W is 2 or 3, and at tick 5 when W is 4 or more.
- R4: On writes, `mem_we` stays high for 4·W ticks when W is 2 or 3, and for 4·W−2 ticks when W is 4 or more.
- R5: After `mem_we` falls, the address and the write-data enable `mem_oe` stay asserted for 5 ticks (W 2..7) or 9 ticks (W ≥ 8). These ticks end at the last tick of the access, and `mem_oe` is low once the access is over.
- R6: On writes, `mem_oe` rises at tick 4: one tick after `mem_we` when W is 2 or 3, and one tick before it when W is 4 or more. While `mem_oe` is high, `mem_dout` carries the accepted write data.
- R7: On reads, `mem_rd` is high from tick 2 through tick 4·W+2. `mem_din` is sampled at the clock edge that ends tick 4·W+2. The sampled value stays on `rdata` until the next read capture. `mem_we` and `mem_oe` stay low throughout a read.
- R8: `req` is sampled only at the edge that ends phase 3 of a core cycle, so an access always starts at phase 0. It is sampled only when idle or on the last tick of an access. Direction, count, address and write data are latched at acceptance, and later changes to them have no effect on the running access.
- R9: If `req` is high on the last tick of an access, the next access starts on the very next tick with no idle core cycle.
- R10: After reset and whenever idle, `busy`, `done`, `mem_aa`, `mem_rd`, `mem_we` and `mem_oe` are low, and `rdata` is zero until the first capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Quarter-tick clock, four times the core rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request |
| wr | input | 1 | Direction: 1 write, 0 read |
| ws_cfg | input | WSW | Programmed wait-state count |
| addr | input | AW | Access address |
| wdata | input | DW | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | High during the final core cycle of an access |
| rdata | output | DW | Last captured read data |
| mem_addr | output | AW | Address to the memory |
| mem_aa | output | 1 | Address-attribute strobe |
| mem_rd | output | 1 | Read strobe |
| mem_we | output | 1 | Write strobe |
| mem_oe | output | 1 | Write-data driver enable |
| mem_dout | output | DW | Write data to the memory |
| mem_din | input | DW | Read data from the memory |

## Verification
The assertions assume that `mem_din` is settled before the clock edge that ends the capture tick. They also assume that the core only changes request fields between clock edges, so the latched values reflect what the core meant. The stimulus respects both assumptions by driving every input on the falling edge. The memory model places the correct read word on `mem_din` only during the capture tick and drives its inverse on every other tick, so a capture made one tick too early or too late shows up as wrong data. After acceptance, the request fields are scrambled mid-access to show that the latched values are the ones in use.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  localparam int RD_ON_TICK = 2;
  localparam int OE_ON_TICK = 4;

  function automatic int eff_ws(input int w);
    return (w < 2) ? 2 : w;
  endfunction

  // total access length in quarter ticks
  function automatic int len_ticks(input int w);
    return (w >= 8) ? 4 * (w + 3) : 4 * (w + 2);
  endfunction

  // tick at which the write strobe rises
  function automatic int we_on_tick(input int w);
    return (w >= 4) ? 5 : 3;
  endfunction

  // tick at which the write strobe falls
  function automatic int we_off_tick(input int w);
    return we_on_tick(w) + ((w >= 4) ? 4 * w - 2 : 4 * w);
  endfunction

  // tick at which the read strobe falls; capture happens on the edge ending the tick before
  function automatic int rd_off_tick(input int w);
    return 4 * w + 3;
  endfunction

endpackage

// File: rtl/quarter_phase.sv
module quarter_phase (
  input  logic       clk,
  input  logic       rst_n,
  output logic [1:0] qph_o,
  output logic       bound_o
);
  logic [1:0] qph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) qph_q <= 2'd0;
    else        qph_q <= qph_q + 2'd1;
  end

  assign qph_o   = qph_q;
  assign bound_o = (qph_q == 2'd3);
endmodule

// File: rtl/access_ctl.sv
module access_ctl
  import sram_seq_pkg::*;
#(
  parameter int AW  = 16,
  parameter int DW  = 16,
  parameter int WSW = 4,
  parameter int CW  = WSW + 1,
  parameter int PW  = CW + 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bound,
  input  logic [1:0]     qph,
  input  logic           req,
  input  logic           wr,
  input  logic [WSW-1:0] ws_cfg,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  output logic           busy_o,
  output logic           start_o,
  output logic           last_o,
  output logic [PW-1:0]  pos_o,
  output logic           is_wr_o,
  output logic [WSW-1:0] ws_o,
  output logic [PW-1:0]  len_o,
  output logic [PW-1:0]  we_on_o,
  output logic [PW-1:0]  we_off_o,
  output logic [PW-1:0]  rd_off_o,
  output logic [AW-1:0]  addr_o,
  output logic [DW-1:0]  wdata_o
);
  logic          busy_q, is_wr_q;
  logic [CW-1:0] cyc_q;
  logic [WSW-1:0] ws_q;
  logic [PW-1:0] len_q, we_on_q, we_off_q, rd_off_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wd_q;
  int            ew;

  assign ew      = eff_ws(int'(ws_cfg));
  assign pos_o   = {cyc_q, qph};
  assign last_o  = busy_q && (pos_o == len_q - PW'(1));
  assign start_o = bound && req && (!busy_q || last_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      is_wr_q  <= 1'b0;
      cyc_q    <= '0;
      ws_q     <= WSW'(2);
      len_q    <= '0;
      we_on_q  <= '0;
      we_off_q <= '0;
      rd_off_q <= '0;
      addr_q   <= '0;
      wd_q     <= '0;
    end else if (start_o) begin
      busy_q   <= 1'b1;
      is_wr_q  <= wr;
      cyc_q    <= '0;
      ws_q     <= WSW'(ew);
      len_q    <= PW'(len_ticks(ew));
      we_on_q  <= PW'(we_on_tick(ew));
      we_off_q <= PW'(we_off_tick(ew));
      rd_off_q <= PW'(rd_off_tick(ew));
      addr_q   <= addr;
      wd_q     <= wdata;
    end else if (busy_q && bound) begin
      if (last_o) busy_q <= 1'b0;
      else        cyc_q  <= cyc_q + CW'(1);
    end
  end

  assign busy_o   = busy_q;
  assign is_wr_o  = is_wr_q;
  assign ws_o     = ws_q;
  assign len_o    = len_q;
  assign we_on_o  = we_on_q;
  assign we_off_o = we_off_q;
  assign rd_off_o = rd_off_q;
  assign addr_o   = addr_q;
  assign wdata_o  = wd_q;
endmodule

// File: rtl/strobe_dec.sv
module strobe_dec
  import sram_seq_pkg::*;
#(
  parameter int DW = 16,
  parameter int PW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic          is_wr,
  input  logic [PW-1:0] pos,
  input  logic [PW-1:0] len,
  input  logic [PW-1:0] we_on,
  input  logic [PW-1:0] we_off,
  input  logic [PW-1:0] rd_off,
  input  logic [DW-1:0] din,
  output logic          aa_o,
  output logic          rd_o,
  output logic          we_o,
  output logic          oe_o,
  output logic          done_o,
  output logic          cap_o,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] rdata_q;
  logic          wr_act, rd_act;

  assign wr_act = busy && is_wr;
  assign rd_act = busy && !is_wr;

  assign aa_o   = busy;
  assign we_o   = wr_act && (pos >= we_on) && (pos < we_off);
  assign oe_o   = wr_act && (pos >= PW'(OE_ON_TICK));
  assign rd_o   = rd_act && (pos >= PW'(RD_ON_TICK)) && (pos < rd_off);
  assign cap_o  = rd_act && (pos == rd_off - PW'(1));
  assign done_o = busy && (pos >= len - PW'(4));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (cap_o) rdata_q <= din;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/sram_strobe_seq.sv
module sram_strobe_seq
  import sram_seq_pkg::*;
#(
  parameter int AW  = 16,
  parameter int DW  = 16,
  parameter int WSW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req,
  input  logic           wr,
  input  logic [WSW-1:0] ws_cfg,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  output logic           busy,
  output logic           done,
  output logic [DW-1:0]  rdata,
  output logic [AW-1:0]  mem_addr,
  output logic           mem_aa,
  output logic           mem_rd,
  output logic           mem_we,
  output logic           mem_oe,
  output logic [DW-1:0]  mem_dout,
  input  logic [DW-1:0]  mem_din
);
  localparam int CW = WSW + 1;
  localparam int PW = CW + 2;

  logic [1:0]     qph;
  logic           bound;
  logic           start_evt, last_evt, cap_evt, is_wr;
  logic [PW-1:0]  pos, len, we_on, we_off, rd_off;
  logic [WSW-1:0] ws_lat;

  quarter_phase u_ph (
    .clk(clk), .rst_n(rst_n), .qph_o(qph), .bound_o(bound)
  );

  access_ctl #(.AW(AW), .DW(DW), .WSW(WSW), .CW(CW), .PW(PW)) u_ctl (
    .clk(clk), .rst_n(rst_n), .bound(bound), .qph(qph),
    .req(req), .wr(wr), .ws_cfg(ws_cfg), .addr(addr), .wdata(wdata),
    .busy_o(busy), .start_o(start_evt), .last_o(last_evt), .pos_o(pos),
    .is_wr_o(is_wr), .ws_o(ws_lat), .len_o(len), .we_on_o(we_on),
    .we_off_o(we_off), .rd_off_o(rd_off), .addr_o(mem_addr), .wdata_o(mem_dout)
  );

  strobe_dec #(.DW(DW), .PW(PW)) u_dec (
    .clk(clk), .rst_n(rst_n), .busy(busy), .is_wr(is_wr), .pos(pos),
    .len(len), .we_on(we_on), .we_off(we_off), .rd_off(rd_off),
    .din(mem_din), .aa_o(mem_aa), .rd_o(mem_rd), .we_o(mem_we),
    .oe_o(mem_oe), .done_o(done), .cap_o(cap_evt), .rdata_o(rdata)
  );
endmodule

module sram_strobe_seq_chk #(
  parameter int DW  = 16,
  parameter int WSW = 4,
  parameter int PW  = 7
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req,
  input logic           busy,
  input logic           done,
  input logic           mem_aa,
  input logic           mem_rd,
  input logic           mem_we,
  input logic           mem_oe,
  input logic [DW-1:0]  mem_din,
  input logic [DW-1:0]  rdata,
  input logic           start_evt,
  input logic           last_evt,
  input logic           cap_evt,
  input logic [1:0]     qph,
  input logic [PW-1:0]  pos,
  input logic [WSW-1:0] ws_lat
);
  // R1
  ws_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> ws_lat >= WSW'(2));
  // R2
  done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  // R2
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done));
  // R3
  we_under_aa_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_aa && !mem_rd);
  // R5
  oe_under_aa_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_oe |-> mem_aa);
  // R7
  rd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> !mem_we && !mem_oe);
  // R7
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> rdata == $past(mem_din));
  // R8
  start_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |-> qph == 2'd3);
  // R9
  chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_evt && req |=> busy && pos == '0);
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_aa && !mem_rd && !mem_we && !mem_oe && !done);
endmodule

bind sram_strobe_seq sram_strobe_seq_chk #(.DW(DW), .WSW(WSW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .busy(busy), .done(done),
  .mem_aa(mem_aa), .mem_rd(mem_rd), .mem_we(mem_we), .mem_oe(mem_oe),
  .mem_din(mem_din), .rdata(rdata), .start_evt(start_evt),
  .last_evt(last_evt), .cap_evt(cap_evt), .qph(qph), .pos(pos), .ws_lat(ws_lat)
);

// File: tb/sim_sram_strobe_seq.sv
`timescale 1ns/1ps
module sim_sram_strobe_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, wr = 1'b0;
  logic [3:0]  ws_cfg = '0;
  logic [15:0] addr = '0, wdata = '0, mem_din = '0;
  logic        busy, done, mem_aa, mem_rd, mem_we, mem_oe;
  logic [15:0] rdata, mem_addr, mem_dout;

  int n_cmp = 0, n_bad = 0, tick = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) tick <= 0;
    else        tick <= tick + 1;
  end

  sram_strobe_seq u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .ws_cfg(ws_cfg),
    .addr(addr), .wdata(wdata), .busy(busy), .done(done), .rdata(rdata),
    .mem_addr(mem_addr), .mem_aa(mem_aa), .mem_rd(mem_rd), .mem_we(mem_we),
    .mem_oe(mem_oe), .mem_dout(mem_dout), .mem_din(mem_din)
  );

  function automatic int b_ws(input int c);  return (c <= 1) ? 2 : c; endfunction
  function automatic int b_len(input int w);  return 4 * w + ((w > 7) ? 12 : 8); endfunction
  function automatic int b_weon(input int w); return (w < 4) ? 3 : 5; endfunction
  function automatic int b_wew(input int w);  return (w < 4) ? 4 * w : 4 * w - 2; endfunction
  function automatic int b_hold(input int w); return (w > 7) ? 9 : 5; endfunction
  function automatic int b_oeon(input int w); return (w < 4) ? b_weon(w) + 1 : b_weon(w) - 1; endfunction
  function automatic logic [15:0] pat(input logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'h5A3C;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d (t=%0t)", rq, what, act, exp, $time);
    end
  endtask

  task automatic run(input bit w, input int c, input logic [15:0] a, input logic [15:0] d,
                     input bit chained, input bit keep);
    int ws = b_ws(c);
    int len = b_len(ws);
    int won = b_weon(ws);
    int woff = won + b_wew(ws);
    logic [15:0] good = pat(a);
    string lq = (c < 2) ? "R1" : "R2";
    bit e_we, e_oe, e_rd, e_done;
    if (!chained) begin
      int n = 0;
      req = 1'b1; wr = w; ws_cfg = 4'(c); addr = a; wdata = d; mem_din = ~good;
      do begin @(negedge clk); n++; end while (!busy && n < 40);
      chk(busy, "R8", "accept", int'(busy), 1);
      chk(tick % 4 == 0, "R8", "start phase", tick % 4, 0);
    end else begin
      @(negedge clk);
      chk(busy && !done, "R9", "chained restart", int'(done), 0);
    end
    for (int k = 0; k < len; k++) begin
      if (k > 0) @(negedge clk);
      e_we   = w && k >= won && k < woff;
      e_oe   = w && k >= 4;
      e_rd   = !w && k >= 2 && k <= 4 * ws + 2;
      e_done = k >= len - 4;
      chk(busy == 1'b1, lq, "busy", int'(busy), 1);
      chk(done == e_done, lq, "done", int'(done), int'(e_done));
      chk(mem_aa == 1'b1 && mem_addr == a, "R3", "aa/addr", int'(mem_addr), int'(a));
      chk(mem_we == e_we, (k < won + 1) ? "R3" : "R4", "we", int'(mem_we), int'(e_we));
      chk(mem_oe == e_oe, (k < 6) ? "R6" : "R5", "oe", int'(mem_oe), int'(e_oe));
      chk(mem_rd == e_rd, "R7", "rd", int'(mem_rd), int'(e_rd));
      if (e_oe) chk(mem_dout == d, "R6", "dout", int'(mem_dout), int'(d));
      if (w && k == woff) chk(len - woff == b_hold(ws), "R5", "hold ticks", len - woff, b_hold(ws));
      mem_din = (!w && k == 4 * ws + 2) ? good : ~good;
      if (k == 0 && !keep) req = 1'b0;
      if (k == 2 && !keep) begin
        wr = ~w; ws_cfg = 4'($urandom); addr = ~a; wdata = ~d;
      end
    end
    if (!w) chk(rdata == good, "R7", "rdata", int'(rdata), int'(good));
    if (!keep) begin
      @(negedge clk);
      chk(!busy && !mem_aa && !mem_we && !mem_oe && !mem_rd, "R10", "idle",
          int'({busy, mem_aa, mem_we, mem_oe, mem_rd}), 0);
      chk(!mem_oe, "R5", "driver released", int'(mem_oe), 0);
    end
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [15:0] held;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!busy && !done && !mem_aa && !mem_rd && !mem_we && !mem_oe && rdata == 16'd0,
        "R10", "reset state", int'({busy, done, mem_aa, mem_rd, mem_we, mem_oe}), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!busy && !mem_aa, "R10", "idle after reset", int'(busy), 0);
    // directed corners: floor, thresholds 4 and 8, maximum
    run(1, 0, 16'h1234, 16'hBEEF, 0, 0);
    run(0, 1, 16'h0F0F, 16'h0000, 0, 0);
    run(1, 3, 16'h2222, 16'hCAFE, 0, 0);
    run(1, 4, 16'h3333, 16'hF00D, 0, 0);
    run(0, 7, 16'h4444, 16'h0000, 0, 0);
    run(1, 8, 16'h5555, 16'h1357, 0, 0);
    run(0, 8, 16'h6666, 16'h0000, 0, 0);
    run(1, 15, 16'h7777, 16'h2468, 0, 0);
    run(0, 15, 16'h8888, 16'h0000, 0, 0);
    // R7 rdata holds across a write
    held = rdata;
    run(1, 2, 16'h9999, 16'hAAAA, 0, 0);
    chk(rdata == held, "R7", "rdata held over write", int'(rdata), int'(held));
    // R9 back-to-back
    run(0, 5, 16'hABCD, 16'h0000, 0, 1);
    run(0, 5, 16'hABCD, 16'h0000, 1, 0);
    run(1, 9, 16'hDCBA, 16'h7E7E, 0, 1);
    run(1, 9, 16'hDCBA, 16'h7E7E, 1, 0);
    // constrained random
    for (int i = 0; i < 60; i++) begin
      run(1'($urandom), int'($urandom % 16), 16'($urandom), 16'($urandom), 0, 0);
      repeat (int'($urandom % 6)) @(negedge clk);
    end
    summary();
  end
endmodule